// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block sits on the host side of a two-wire management bus. It takes one command request and breaks it into an ordered list of byte-level operations for a separate bit-level bus engine: start with an address and direction byte, send a byte, receive a byte, master NACK, and stop. Each operation is offered on a valid/ready handshake. The sequencer waits for the engine to accept one operation before it presents the next.

Nine transaction kinds are supported. They are quick command, send byte, receive byte, write and read of a byte, write and read of a 16-bit word, and write and read of a length-prefixed block. Reads that carry a command code switch direction with a repeated start. Words travel low byte first. Block payloads pass through an internal byte buffer of `BUF_DEPTH` entries. The host fills this buffer before a block write and reads it back after a block read, through a small port that is usable only while the block is idle.

Top module: `smb_cmd_seq`

## Requirements
- R1: A pulse on `req_valid` with `req_proto` in 0..8 while idle raises `busy` on the next cycle. `busy` holds until completion. Requests made while busy, and codes 9..15 at any time, start nothing.
- R2: Each operation is presented with `eng_valid` high, and `eng_op`/`eng_data` stay stable until `eng_ready` is seen high at a clock edge. No further operation is presented before that.
- R3: Quick command (code 0) issues START with data `{addr, req_rnw}`, then STOP. A start byte always carries the 7-bit address in bits 7:1 and the direction in bit 0, where 1 means read.
- R4: Send byte (code 1) issues START `{addr,0}`, SEND `req_wdata[7:0]`, STOP. Receive byte (code 2) issues START `{addr,1}`, RECV, NACK, STOP, and returns the byte in `rd_data[7:0]`.
- R5: Write byte (code 3) and write word (code 5) issue START `{addr,0}`, SEND `req_cmd`, SEND `req_wdata[7:0]`, then SEND `req_wdata[15:8]` for the word only, then STOP.
- R6: Read byte (code 4) and read word (code 6) issue START `{addr,0}`, SEND `req_cmd`, START `{addr,1}`, one or two RECV, NACK, STOP. `rd_data` is little-endian: the first byte goes to bits 7:0 and the second to bits 15:8. For read byte, bits 15:8 are zero.
- R7: Block write (code 7) limits `req_wlen` to 32. It issues START `{addr,0}`, SEND `req_cmd`, SEND length, SEND of buffer entries 0 to length-1, STOP, and reports the limited length on `blk_len`.
- R8: Block read (code 8) issues START `{addr,0}`, SEND `req_cmd`, START `{addr,1}`, RECV of a length byte, where a value above 32 counts as 0. It then issues that many RECVs, stored in buffer entries 0 upward, then NACK and STOP, and reports the length on `blk_len`.
- R9: NACK follows only the last RECV of a transaction; every earlier received byte is acknowledged implicitly.
- R10: `done` pulses for exactly one cycle, in the cycle `busy` falls, after the STOP operation is accepted. `rd_data` and `blk_len` are valid from that cycle. Both are zero for kinds that do not produce them.
- R11: While idle, `buf_we` writes `buf_wdata` at `buf_addr`, and `buf_rdata` shows the entry at `buf_addr` one cycle after the address is applied. Host writes while busy are ignored.
- R12: Operation codes on `eng_op` are START=1, SEND=2, RECV=3, NACK=4, STOP=5. `eng_data` is zero for RECV, NACK and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_proto | input | 4 | Transaction kind code 0..8 |
| req_addr | input | 7 | Target 7-bit address |
| req_rnw | input | 1 | Direction for quick command (1 = read) |
| req_cmd | input | 8 | Command code byte |
| req_wdata | input | 16 | Write data for byte/word/send kinds |
| req_wlen | input | 8 | Requested block write length |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, little-endian |
| blk_len | output | $clog2(BUF_DEPTH+1) | Block length used |
| buf_we | input | 1 | Host buffer write enable |
| buf_addr | input | $clog2(BUF_DEPTH) | Host buffer address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Host buffer read data, one-cycle latency |
| eng_valid | output | 1 | Operation offered to byte engine |
| eng_op | output | 3 | Operation code |
| eng_data | output | 8 | Operation byte |
| eng_ready | input | 1 | Engine accepts the operation |
| eng_rdata | input | 8 | Received byte, valid with eng_ready on RECV |

## Verification
The bench builds the block with the default `BUF_DEPTH` of 32, which equals the protocol length cap. Block writes of exactly 32, 33 and 200 bytes therefore exercise the clamp. Block reads with a length byte of 32 fill every buffer entry and drive the internal index to its top value. A length byte of 33 or 255 covers the over-length case, which becomes an immediate NACK after the length byte. The engine model stretches each handshake by a random 0 to 3 cycles, so stable operation presentation is exercised as well as the orderings.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

  typedef enum logic [3:0] {
    PR_QUICK   = 4'd0,
    PR_SEND    = 4'd1,
    PR_RECV    = 4'd2,
    PR_WR_BYTE = 4'd3,
    PR_RD_BYTE = 4'd4,
    PR_WR_WORD = 4'd5,
    PR_RD_WORD = 4'd6,
    PR_BLK_WR  = 4'd7,
    PR_BLK_RD  = 4'd8
  } proto_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_SEND  = 3'd2,
    OP_RECV  = 3'd3,
    OP_NACK  = 3'd4,
    OP_STOP  = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    PH_START, PH_CMD, PH_WLO, PH_WHI, PH_BLEN_W, PH_BDATA_W,
    PH_RSTART, PH_RLO, PH_RHI, PH_BLEN_R, PH_BDATA_R, PH_NACK, PH_STOP
  } phase_e;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LOAD, S_ISSUE} state_e;

  function automatic logic proto_legal(input logic [3:0] p);
    return p <= 4'd8;
  endfunction

endpackage

// File: rtl/smb_seq_buf.sv
module smb_seq_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/smb_seq_step.sv
module smb_seq_step
  import smb_seq_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  proto_e           proto,
  input  phase_e           phase,
  input  logic [LEN_W-1:0] idx,
  input  logic [LEN_W-1:0] len,
  output phase_e           nxt
);
  logic last_byte;
  assign last_byte = (idx + LEN_W'(1)) == len;

  always_comb begin
    nxt = PH_STOP;
    case (phase)
      PH_START: begin
        case (proto)
          PR_QUICK: nxt = PH_STOP;
          PR_RECV:  nxt = PH_RLO;
          PR_SEND:  nxt = PH_WLO;
          default:  nxt = PH_CMD;
        endcase
      end
      PH_CMD: begin
        case (proto)
          PR_WR_BYTE, PR_WR_WORD: nxt = PH_WLO;
          PR_BLK_WR:              nxt = PH_BLEN_W;
          default:                nxt = PH_RSTART;
        endcase
      end
      PH_WLO:     nxt = (proto == PR_WR_WORD) ? PH_WHI : PH_STOP;
      PH_WHI:     nxt = PH_STOP;
      PH_BLEN_W:  nxt = (len == '0) ? PH_STOP : PH_BDATA_W;
      PH_BDATA_W: nxt = last_byte ? PH_STOP : PH_BDATA_W;
      PH_RSTART:  nxt = (proto == PR_BLK_RD) ? PH_BLEN_R : PH_RLO;
      PH_RLO:     nxt = (proto == PR_RD_WORD) ? PH_RHI : PH_NACK;
      PH_RHI:     nxt = PH_NACK;
      PH_BLEN_R:  nxt = (len == '0) ? PH_NACK : PH_BDATA_R;
      PH_BDATA_R: nxt = last_byte ? PH_NACK : PH_BDATA_R;
      PH_NACK:    nxt = PH_STOP;
      default:    nxt = PH_STOP;
    endcase
  end
endmodule

// File: rtl/smb_seq_opgen.sv
module smb_seq_opgen
  import smb_seq_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  phase_e           phase,
  input  proto_e           proto,
  input  logic [6:0]       addr,
  input  logic             rnw,
  input  logic [7:0]       cmd,
  input  logic [15:0]      wdata,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       bufq,
  output op_e              op,
  output logic [7:0]       data
);
  logic first_dir;
  assign first_dir = (proto == PR_QUICK) ? rnw : (proto == PR_RECV);

  always_comb begin
    op   = OP_STOP;
    data = 8'h00;
    case (phase)
      PH_START:   begin op = OP_START; data = {addr, first_dir}; end
      PH_RSTART:  begin op = OP_START; data = {addr, 1'b1};      end
      PH_CMD:     begin op = OP_SEND;  data = cmd;               end
      PH_WLO:     begin op = OP_SEND;  data = wdata[7:0];        end
      PH_WHI:     begin op = OP_SEND;  data = wdata[15:8];       end
      PH_BLEN_W:  begin op = OP_SEND;  data = 8'(len);           end
      PH_BDATA_W: begin op = OP_SEND;  data = bufq;              end
      PH_RLO, PH_RHI, PH_BLEN_R, PH_BDATA_R: op = OP_RECV;
      PH_NACK:    op = OP_NACK;
      default:    op = OP_STOP;
    endcase
  end
endmodule

// File: rtl/smb_cmd_seq.sv
module smb_cmd_seq
  import smb_seq_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int AW    = $clog2(BUF_DEPTH),
  localparam int LEN_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [3:0]       req_proto,
  input  logic [6:0]       req_addr,
  input  logic             req_rnw,
  input  logic [7:0]       req_cmd,
  input  logic [15:0]      req_wdata,
  input  logic [7:0]       req_wlen,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic [LEN_W-1:0] blk_len,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_wdata,
  output logic [7:0]       buf_rdata,
  output logic             eng_valid,
  output logic [2:0]       eng_op,
  output logic [7:0]       eng_data,
  input  logic             eng_ready,
  input  logic [7:0]       eng_rdata
);
  state_e           state_q;
  phase_e           phase_q, phase_n;
  proto_e           proto_q;
  logic [6:0]       addr_q;
  logic             rnw_q;
  logic [7:0]       cmd_q;
  logic [15:0]      wdata_q;
  logic [LEN_W-1:0] len_q, idx_q, step_len, rx_len, wlen_lim;
  logic [7:0]       rd_lo_q, rd_hi_q, ram_q;
  op_e              op_n;
  logic [7:0]       data_n;
  logic             accept, fire, ram_we;
  logic [AW-1:0]    ram_waddr, ram_raddr;

  assign accept   = (state_q == S_IDLE) && req_valid && proto_legal(req_proto);
  assign fire     = (state_q == S_ISSUE) && eng_ready;
  assign wlen_lim = (req_wlen > 8'(BUF_DEPTH)) ? LEN_W'(BUF_DEPTH) : req_wlen[LEN_W-1:0];
  assign rx_len   = (eng_rdata > 8'(BUF_DEPTH)) ? '0 : eng_rdata[LEN_W-1:0];
  assign step_len = (phase_q == PH_BLEN_R) ? rx_len : len_q;

  // buffer port: host owns it while idle, sequencer while busy
  assign ram_we    = busy ? (fire && phase_q == PH_BDATA_R) : buf_we;
  assign ram_waddr = busy ? idx_q[AW-1:0] : buf_addr;
  assign ram_raddr = busy ? idx_q[AW-1:0] : buf_addr;
  assign buf_rdata = ram_q;

  smb_seq_buf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (busy ? eng_rdata : buf_wdata),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  smb_seq_step #(.LEN_W(LEN_W)) u_step (
    .proto (proto_q),
    .phase (phase_q),
    .idx   (idx_q),
    .len   (step_len),
    .nxt   (phase_n)
  );

  smb_seq_opgen #(.LEN_W(LEN_W)) u_opgen (
    .phase (phase_q),
    .proto (proto_q),
    .addr  (addr_q),
    .rnw   (rnw_q),
    .cmd   (cmd_q),
    .wdata (wdata_q),
    .len   (len_q),
    .bufq  (ram_q),
    .op    (op_n),
    .data  (data_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      phase_q   <= PH_START;
      proto_q   <= PR_QUICK;
      addr_q    <= '0;
      rnw_q     <= 1'b0;
      cmd_q     <= '0;
      wdata_q   <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      rd_lo_q   <= '0;
      rd_hi_q   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rd_data   <= '0;
      blk_len   <= '0;
      eng_valid <= 1'b0;
      eng_op    <= '0;
      eng_data  <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_FETCH;
          phase_q <= PH_START;
          proto_q <= proto_e'(req_proto);
          addr_q  <= req_addr;
          rnw_q   <= req_rnw;
          cmd_q   <= req_cmd;
          wdata_q <= req_wdata;
          len_q   <= (proto_e'(req_proto) == PR_BLK_WR) ? wlen_lim : '0;
          idx_q   <= '0;
          rd_lo_q <= '0;
          rd_hi_q <= '0;
          busy    <= 1'b1;
        end
        S_FETCH: state_q <= S_LOAD;
        S_LOAD: begin
          state_q   <= S_ISSUE;
          eng_valid <= 1'b1;
          eng_op    <= op_n;
          eng_data  <= data_n;
        end
        default: if (fire) begin
          eng_valid <= 1'b0;
          case (phase_q)
            PH_RLO:                 rd_lo_q <= eng_rdata;
            PH_RHI:                 rd_hi_q <= eng_rdata;
            PH_BLEN_R:              len_q   <= rx_len;
            PH_BDATA_R, PH_BDATA_W: idx_q   <= idx_q + LEN_W'(1);
            default: ;
          endcase
          if (phase_q == PH_STOP) begin
            state_q <= S_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
            rd_data <= {rd_hi_q, rd_lo_q};
            blk_len <= len_q;
          end else begin
            state_q <= S_FETCH;
            phase_q <= phase_n;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/smb_cmd_seq_chk.sv
module smb_cmd_seq_chk #(
  parameter int BUF_DEPTH = 32,
  localparam int LEN_W = $clog2(BUF_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             eng_valid,
  input logic             eng_ready,
  input logic [2:0]       eng_op,
  input logic [7:0]       eng_data,
  input logic [LEN_W-1:0] blk_len
);
  a_r2_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    eng_valid && !eng_ready |=> eng_valid && $stable(eng_op) && $stable(eng_data));

  a_r1_valid_only_busy: assert property (@(posedge clk) disable iff (rst)
    eng_valid |-> busy);

  a_r10_done_after_stop: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(eng_valid && eng_ready && eng_op == 3'd5));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r12_legal_op: assert property (@(posedge clk) disable iff (rst)
    eng_valid |-> (eng_op >= 3'd1 && eng_op <= 3'd5));

  a_r7_len_cap: assert property (@(posedge clk) disable iff (rst)
    blk_len <= LEN_W'(BUF_DEPTH));
endmodule

bind smb_cmd_seq smb_cmd_seq_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .eng_valid (eng_valid),
  .eng_ready (eng_ready),
  .eng_op    (eng_op),
  .eng_data  (eng_data),
  .blk_len   (blk_len)
);

// File: tb/smb_cmd_seq_tb.sv
module smb_cmd_seq_tb_top;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int MAXOP = 80;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_rnw = 0;
  logic [3:0] req_proto = 0;
  logic [6:0] req_addr = 0;
  logic [7:0] req_cmd = 0, req_wlen = 0;
  logic [15:0] req_wdata = 0;
  logic busy, done, eng_valid;
  logic [15:0] rd_data;
  logic [LW-1:0] blk_len;
  logic buf_we = 0;
  logic [AW-1:0] buf_addr = 0;
  logic [7:0] buf_wdata = 0, buf_rdata, eng_data;
  logic [2:0] eng_op;
  logic eng_ready = 0;
  logic [7:0] eng_rdata = 0;

  always #5 clk = ~clk;

  smb_cmd_seq #(.BUF_DEPTH(DEPTH)) dut_i (.*);

  int checks = 0, failures = 0, hs_err = 0, cycles = 0;
  logic [2:0] exp_op [MAXOP];  logic [7:0] exp_dat [MAXOP];  int exp_n;
  logic [2:0] log_op [MAXOP];  logic [7:0] log_dat [MAXOP];  int log_n;
  logic [7:0] rx_q [MAXOP];    int rx_ptr;
  logic [7:0] mdl [DEPTH];
  logic [15:0] exp_rd;
  int exp_bl;

  task automatic chk(input string rq, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // byte engine model: random handshake stretch, logs accepted ops (R2)
  int wait_cnt = 0;
  bit holding = 0;
  logic [2:0] seen_op;
  logic [7:0] seen_dat;
  always @(negedge clk) begin
    if (rst) begin
      eng_ready = 0; holding = 0;
    end else if (eng_ready) begin
      eng_ready = 0; holding = 0;
    end else if (eng_valid) begin
      if (!holding) begin
        holding = 1; seen_op = eng_op; seen_dat = eng_data; wait_cnt = $urandom % 4;
      end else if (eng_op != seen_op || eng_data != seen_dat) hs_err++;
      if (wait_cnt == 0) begin
        if (log_n < MAXOP) begin
          log_op[log_n] = eng_op; log_dat[log_n] = eng_data; log_n++;
        end
        if (eng_op == 3'd3) begin
          eng_rdata = (rx_ptr < MAXOP) ? rx_q[rx_ptr] : 8'h00;
          rx_ptr++;
        end
        eng_ready = 1;
      end else wait_cnt--;
    end
  end

  function automatic string rq_of(input int pr);
    case (pr)
      0: return "R3";
      1, 2: return "R4";
      3, 5: return "R5";
      4, 6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic push(input logic [2:0] o, input logic [7:0] d);
    exp_op[exp_n] = o; exp_dat[exp_n] = d; exp_n++;
  endtask

  // expected operation list from the requirements (R3..R9, R12)
  task automatic plan(input int pr, input logic [6:0] a, input logic rw, input logic [7:0] c,
                      input logic [15:0] wd, input logic [7:0] wl, input logic [7:0] rlen);
    int n;
    exp_n = 0; log_n = 0; rx_ptr = 0; exp_rd = 0; exp_bl = 0;
    for (int i = 0; i < MAXOP; i++) rx_q[i] = 8'($urandom);
    case (pr)
      0: begin push(1, {a, rw}); push(5, 0); end
      1: begin push(1, {a, 1'b0}); push(2, wd[7:0]); push(5, 0); end
      2: begin push(1, {a, 1'b1}); push(3, 0); push(4, 0); push(5, 0); exp_rd = {8'h00, rx_q[0]}; end
      3, 5: begin
        push(1, {a, 1'b0}); push(2, c); push(2, wd[7:0]);
        if (pr == 5) push(2, wd[15:8]);
        push(5, 0);
      end
      4, 6: begin
        push(1, {a, 1'b0}); push(2, c); push(1, {a, 1'b1}); push(3, 0);
        if (pr == 6) push(3, 0);
        push(4, 0); push(5, 0);
        exp_rd = (pr == 6) ? {rx_q[1], rx_q[0]} : {8'h00, rx_q[0]};
      end
      7: begin
        n = (wl > 32) ? 32 : int'(wl);
        push(1, {a, 1'b0}); push(2, c); push(2, 8'(n));
        for (int i = 0; i < n; i++) push(2, mdl[i]);
        push(5, 0); exp_bl = n;
      end
      default: begin
        rx_q[0] = rlen;
        n = (rlen > 32) ? 0 : int'(rlen);
        push(1, {a, 1'b0}); push(2, c); push(1, {a, 1'b1}); push(3, 0);
        for (int i = 0; i < n; i++) begin push(3, 0); mdl[i] = rx_q[i + 1]; end
        push(4, 0); push(5, 0); exp_bl = n;
      end
    endcase
  endtask

  task automatic fire_req(input int pr, input logic [6:0] a, input logic rw, input logic [7:0] c,
                          input logic [15:0] wd, input logic [7:0] wl);
    @(negedge clk);
    req_valid = 1; req_proto = 4'(pr); req_addr = a; req_rnw = rw;
    req_cmd = c; req_wdata = wd; req_wlen = wl;
    @(negedge clk);
    req_valid = 0;
    chk("R1 busy after accept", busy === 1'b1, busy, 1);
  endtask

  task automatic finish_txn(input int pr);
    string rq;
    bit ok;
    int bad;
    rq = rq_of(pr);
    while (done !== 1'b1) @(negedge clk);
    chk("R10 busy low with done", busy === 1'b0, busy, 0);
    ok = (log_n == exp_n); bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && (log_op[i] !== exp_op[i] || log_dat[i] !== exp_dat[i])) bad = i;
    if (bad >= 0) begin
      ok = 0;
      $display("  op %0d: got %0d/%02h want %0d/%02h", bad, log_op[bad], log_dat[bad],
               exp_op[bad], exp_dat[bad]);
    end
    chk({rq, " R9 R12 op sequence"}, ok, log_n, exp_n);
    chk({rq, " R10 rd_data"}, rd_data === exp_rd, rd_data, exp_rd);
    chk({rq, " R10 blk_len"}, int'(blk_len) == exp_bl, blk_len, exp_bl);
    @(negedge clk);
    chk("R10 done one cycle", done === 1'b0, done, 0);
  endtask

  task automatic buf_write(input int i, input logic [7:0] d);
    @(negedge clk);
    buf_we = 1; buf_addr = AW'(i); buf_wdata = d;
    @(negedge clk);
    buf_we = 0;
  endtask

  task automatic buf_read(input int i, output logic [7:0] d);
    @(negedge clk);
    buf_addr = AW'(i);
    @(negedge clk);
    d = buf_rdata;
  endtask

  task automatic do_txn(input int pr, input logic [6:0] a, input logic rw, input logic [7:0] c,
                        input logic [15:0] wd, input logic [7:0] wl, input logic [7:0] rlen);
    logic [7:0] d;
    plan(pr, a, rw, c, wd, wl, rlen);
    fire_req(pr, a, rw, c, wd, wl);
    finish_txn(pr);
    if (pr == 8)
      for (int i = 0; i < exp_bl; i++) begin
        buf_read(i, d);
        chk("R8 buffer content", d === mdl[i], d, mdl[i]);
      end
  endtask

  initial begin
    logic [7:0] d;
    int pr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset busy", busy === 1'b0, busy, 0);
    chk("R12 reset eng_valid", eng_valid === 1'b0, eng_valid, 0);
    chk("R10 reset outputs", done === 1'b0 && rd_data === 16'h0 && blk_len === '0, rd_data, 0);

    // R11 host buffer load and readback
    for (int i = 0; i < DEPTH; i++) begin mdl[i] = 8'($urandom); buf_write(i, mdl[i]); end
    buf_read(0, d);  chk("R11 host readback 0", d === mdl[0], d, mdl[0]);
    buf_read(31, d); chk("R11 host readback 31", d === mdl[31], d, mdl[31]);

    // directed kinds
    do_txn(0, 7'h2A, 1'b0, 0, 0, 0, 0);           // R3 quick write
    do_txn(0, 7'h55, 1'b1, 0, 0, 0, 0);           // R3 quick read
    do_txn(1, 7'h10, 0, 8'h00, 16'h00C3, 0, 0);   // R4 send byte
    do_txn(2, 7'h11, 0, 0, 0, 0, 0);              // R4 receive byte
    do_txn(3, 7'h12, 0, 8'h07, 16'h005A, 0, 0);   // R5 write byte
    do_txn(5, 7'h13, 0, 8'h08, 16'hBEEF, 0, 0);   // R5 write word, low byte first
    do_txn(4, 7'h14, 0, 8'h09, 0, 0, 0);          // R6 read byte
    do_txn(6, 7'h15, 0, 8'h0A, 0, 0, 0);          // R6 read word little-endian
    do_txn(7, 7'h20, 0, 8'h30, 0, 8'd0, 0);       // R7 empty block
    do_txn(7, 7'h21, 0, 8'h31, 0, 8'd32, 0);      // R7 full block
    do_txn(7, 7'h22, 0, 8'h32, 0, 8'd33, 0);      // R7 clamp
    do_txn(7, 7'h23, 0, 8'h33, 0, 8'd200, 0);     // R7 clamp
    do_txn(8, 7'h24, 0, 8'h34, 0, 0, 8'd0);       // R8 zero length
    do_txn(8, 7'h25, 0, 8'h35, 0, 0, 8'd32);      // R8 full length
    do_txn(8, 7'h26, 0, 8'h36, 0, 0, 8'd33);      // R8 over-length -> 0
    do_txn(8, 7'h27, 0, 8'h37, 0, 0, 8'hFF);      // R8 over-length -> 0

    // R1/R11: request and host write during busy are ignored
    d = mdl[0];
    plan(0, 7'h3C, 1'b0, 0, 0, 0, 0);
    fire_req(0, 7'h3C, 1'b0, 0, 0, 0);
    @(negedge clk);
    req_valid = 1; req_proto = 4'd8; req_addr = 7'h01;
    buf_we = 1; buf_addr = '0; buf_wdata = ~d;
    @(negedge clk);
    req_valid = 0; buf_we = 0;
    finish_txn(0);
    repeat (3) @(negedge clk);
    chk("R1 no start after busy request", busy === 1'b0 && eng_valid === 1'b0, busy, 0);
    buf_read(0, d);
    chk("R11 busy host write ignored", d === mdl[0], d, mdl[0]);

    // R1 illegal codes
    foreach (mdl[k]) if (k < 2) begin
      @(negedge clk);
      req_valid = 1; req_proto = (k == 0) ? 4'd9 : 4'd15;
      @(negedge clk);
      req_valid = 0;
      repeat (3) @(negedge clk);
      chk("R1 illegal code ignored", busy === 1'b0 && eng_valid === 1'b0, busy, 0);
    end

    // random mix
    for (int t = 0; t < 40; t++) begin
      pr = $urandom % 9;
      do_txn(pr, 7'($urandom), 1'($urandom), 8'($urandom), 16'($urandom),
             8'($urandom % 40), ($urandom % 5 == 0) ? 8'($urandom) : 8'($urandom % 34));
    end

    chk("R2 op stable while waiting", hs_err == 0, hs_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule